// File: doc/BRIEF.md
# DRP Register Bridge

This block connects a processor's memory-mapped register bus to the dynamic reconfiguration port of a clock synthesizer. The host sees four 32-bit registers. One releases the core reset and gates the synthesizer on. One selects the clock source. One starts a reconfiguration access. One reports whether an access is in flight and holds the data returned by the last read.

A single host write to the control register launches a whole port access. That word carries a start flag, a direction flag, the 7-bit port address and 16 bits of write data. The bridge pulses the port enable for one cycle and holds address, data and direction steady. It then waits for the port's ready strobe, however many cycles that takes. The host polls the busy flag in the status word before and after each access. On a read, it takes the result from the low half of the same word.

The bus side is a plain single-cycle register interface. A write takes effect at the clock edge where `bus_wr` is high. A read returns data combinationally for the current `bus_addr`.

Top module: `drp_bridge`

## Requirements
- R1: After reset, every register reads zero, `core_release`, `synth_en`, `drp_en` and `clk_sel` are low, and the status busy flag (bit 16 at offset 0x74) is clear.
- R2: A write to offset 0x40 stores bits 1:0. Bit 0 drives `core_release` and bit 1 drives `synth_en`. Writing the value 1 releases the core while the synthesizer stays disabled. The register reads back its two bits with all upper bits zero.
- R3: A write to offset 0x44 stores the low CLKSEL_W bits. They drive `clk_sel` and read back unchanged, zero-extended.
- R4: A write to offset 0x70 with bit 29 set, made while idle, starts an access. In the next cycle `drp_en` is high for exactly one cycle, `drp_addr` equals control bits 22:16 and `drp_di` equals bits 15:0. `drp_we` is low when bit 28 is set (read) and high when it is clear (write).
- R5: A control write with bit 29 clear starts nothing: `drp_en` stays low and busy stays clear.
- R6: Status bit 16 (busy) is set from the edge that accepts the control write. It is still set in the cycle `drp_rdy` is high, and clears at the following edge.
- R7: A control write made while busy is ignored. No enable pulse follows, `drp_addr`, `drp_di` and `drp_we` keep their values, and the access in flight completes with its own result.
- R8: When a read access completes, `drp_do` is captured into status bits 15:0 at the `drp_rdy` edge. A completing write leaves those bits unchanged, and they hold until the next read completes.
- R9: Control bits 27:23 have no effect on the port address or on any other output.
- R10: Reads of any offset other than 0x40, 0x44 and 0x74 return zero, including the write-only control offset 0x70. Status bits 31:17 always read zero.
- R11: A `drp_rdy` pulse while no access is in flight changes neither busy nor status bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 9 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| core_release | output | 1 | Core reset release (reset register bit 0) |
| synth_en | output | 1 | Synthesizer enable (reset register bit 1) |
| clk_sel | output | CLKSEL_W | Clock source select |
| drp_en | output | 1 | Port enable, one-cycle pulse per access |
| drp_we | output | 1 | Port write enable, high for a write access |
| drp_addr | output | 7 | Port register address |
| drp_di | output | 16 | Port write data |
| drp_do | input | 16 | Port read data |
| drp_rdy | input | 1 | Port completion strobe |

## Verification
Two situations are the hardest to reach from the ports. One is a control write that lands while an access is still in flight. The other is a ready pulse that arrives with nothing pending. For the first, the bench's behavioural synthesizer model is given a long response latency, and a second control write aimed at a different address is issued in the middle of that window. The data returned then shows whether the first access survived. For the second, the bench injects a stray ready pulse with a distinctive data word while idle.

The main traffic is a full sweep. A write goes to every port address, then a read comes back from every address. Response latencies vary across the sweep, and junk sits in the ignored address bits.

// File: rtl/drp_bridge_pkg.sv
package drp_bridge_pkg;

    localparam int BUS_AW = 9;
    localparam int BUS_DW = 32;
    localparam int DRP_AW = 7;
    localparam int DRP_DW = 16;

    // register offsets the host software depends on
    localparam logic [BUS_AW-1:0] OFS_RESET  = 9'h040;
    localparam logic [BUS_AW-1:0] OFS_CLKSEL = 9'h044;
    localparam logic [BUS_AW-1:0] OFS_CTRL   = 9'h070;
    localparam logic [BUS_AW-1:0] OFS_STATUS = 9'h074;

    // control word bit positions
    localparam int CTRL_GO_BIT   = 29;
    localparam int CTRL_RD_BIT   = 28;
    localparam int CTRL_ADDR_LSB = 16;
    localparam int STAT_BUSY_BIT = 16;

    typedef struct packed {
        logic              go;
        logic              rd;
        logic [DRP_AW-1:0] addr;
        logic [DRP_DW-1:0] data;
    } drp_req_t;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_LAUNCH = 2'd1,
        SEQ_WAIT   = 2'd2
    } seq_state_t;

    function automatic drp_req_t decode_ctrl(input logic [BUS_DW-1:0] w);
        drp_req_t r;
        r.go   = w[CTRL_GO_BIT];
        r.rd   = w[CTRL_RD_BIT];
        r.addr = w[CTRL_ADDR_LSB +: DRP_AW];
        r.data = w[DRP_DW-1:0];
        return r;
    endfunction

    function automatic logic [BUS_DW-1:0] pack_status(input logic busy,
                                                      input logic [DRP_DW-1:0] rdata);
        logic [BUS_DW-1:0] s;
        s = '0;
        s[STAT_BUSY_BIT]  = busy;
        s[DRP_DW-1:0]     = rdata;
        return s;
    endfunction

endpackage

// File: rtl/drp_cfg_regs.sv
module drp_cfg_regs
    import drp_bridge_pkg::*;
#(
    parameter int CLKSEL_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [BUS_AW-1:0]   bus_addr,
    input  logic [BUS_DW-1:0]   bus_wdata,
    output logic [1:0]          rst_bits,
    output logic [CLKSEL_W-1:0] clksel
);

    logic wr_reset;
    logic wr_clksel;

    always_comb begin
        wr_reset  = bus_wr && (bus_addr == OFS_RESET);
        wr_clksel = bus_wr && (bus_addr == OFS_CLKSEL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_bits <= '0;
            clksel   <= '0;
        end else begin
            if (wr_reset)
                rst_bits <= bus_wdata[1:0];
            if (wr_clksel)
                clksel <= bus_wdata[CLKSEL_W-1:0];
        end
    end

endmodule

// File: rtl/drp_access_seq.sv
module drp_access_seq
    import drp_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic              drp_en,
    output logic              drp_we,
    output logic [DRP_AW-1:0] drp_addr,
    output logic [DRP_DW-1:0] drp_di,
    input  logic [DRP_DW-1:0] drp_do,
    input  logic              drp_rdy,
    output logic              busy,
    output logic [DRP_DW-1:0] rd_data
);

    seq_state_t state_q;
    drp_req_t   req_q;
    drp_req_t   req_in;
    logic       start;
    logic       done;

    always_comb begin
        req_in = decode_ctrl(bus_wdata);
        start  = bus_wr && (bus_addr == OFS_CTRL) && req_in.go && (state_q == SEQ_IDLE);
        done   = (state_q != SEQ_IDLE) && drp_rdy;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            req_q   <= '0;
            rd_data <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        state_q <= SEQ_LAUNCH;
                        req_q   <= req_in;
                    end
                end
                SEQ_LAUNCH: state_q <= done ? SEQ_IDLE : SEQ_WAIT;
                SEQ_WAIT:   if (done) state_q <= SEQ_IDLE;
                default:    state_q <= SEQ_IDLE;
            endcase
            if (done && req_q.rd)
                rd_data <= drp_do;
        end
    end

    always_comb begin
        busy     = (state_q != SEQ_IDLE);
        drp_en   = (state_q == SEQ_LAUNCH);
        drp_we   = ~req_q.rd;
        drp_addr = req_q.addr;
        drp_di   = req_q.data;
    end

endmodule

// File: rtl/drp_read_mux.sv
module drp_read_mux
    import drp_bridge_pkg::*;
#(
    parameter int CLKSEL_W = 8
) (
    input  logic [BUS_AW-1:0]   bus_addr,
    input  logic [1:0]          rst_bits,
    input  logic [CLKSEL_W-1:0] clksel,
    input  logic                busy,
    input  logic [DRP_DW-1:0]   rd_data,
    output logic [BUS_DW-1:0]   bus_rdata
);

    localparam int PAD_RST = BUS_DW - 2;
    localparam int PAD_SEL = BUS_DW - CLKSEL_W;

    always_comb begin
        unique case (bus_addr)
            OFS_RESET:  bus_rdata = {{PAD_RST{1'b0}}, rst_bits};
            OFS_CLKSEL: bus_rdata = {{PAD_SEL{1'b0}}, clksel};
            OFS_STATUS: bus_rdata = pack_status(busy, rd_data);
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/drp_bridge.sv
module drp_bridge
    import drp_bridge_pkg::*;
#(
    parameter int CLKSEL_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [8:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                core_release,
    output logic                synth_en,
    output logic [CLKSEL_W-1:0] clk_sel,
    output logic                drp_en,
    output logic                drp_we,
    output logic [6:0]          drp_addr,
    output logic [15:0]         drp_di,
    input  logic [15:0]         drp_do,
    input  logic                drp_rdy
);

    logic [1:0]        rst_bits;
    logic              seq_busy;
    logic [DRP_DW-1:0] seq_rd_data;

    drp_cfg_regs #(.CLKSEL_W(CLKSEL_W)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .rst_bits  (rst_bits),
        .clksel    (clk_sel)
    );

    drp_access_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .drp_en    (drp_en),
        .drp_we    (drp_we),
        .drp_addr  (drp_addr),
        .drp_di    (drp_di),
        .drp_do    (drp_do),
        .drp_rdy   (drp_rdy),
        .busy      (seq_busy),
        .rd_data   (seq_rd_data)
    );

    drp_read_mux #(.CLKSEL_W(CLKSEL_W)) u_mux (
        .bus_addr  (bus_addr),
        .rst_bits  (rst_bits),
        .clksel    (clk_sel),
        .busy      (seq_busy),
        .rd_data   (seq_rd_data),
        .bus_rdata (bus_rdata)
    );

    always_comb begin
        core_release = rst_bits[0];
        synth_en     = rst_bits[1];
    end

endmodule

// File: rtl/drp_bridge_chk.sv
module drp_bridge_chk
    import drp_bridge_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        bus_wr,
    input logic [8:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic        core_release,
    input logic        synth_en,
    input logic        drp_en,
    input logic        drp_rdy,
    input logic        seq_busy,
    input logic [15:0] seq_rd_data
);

    // R4
    en_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        drp_en |=> !drp_en);

    // R4
    launch_on_busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_busy) |-> drp_en);

    // R6
    en_within_busy_chk: assert property (@(posedge clk) disable iff (rst)
        drp_en |-> seq_busy);

    // R6
    busy_clears_on_rdy_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_busy && drp_rdy) |=> !seq_busy);

    // R7
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_busy && bus_wr && bus_addr == OFS_CTRL) |=> !drp_en);

    // R8
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(seq_busy && drp_rdy) |=> $stable(seq_rd_data));

    // R2
    reset_reg_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_RESET) |=>
            (synth_en == $past(bus_wdata[1]) && core_release == $past(bus_wdata[0])));

endmodule

bind drp_bridge drp_bridge_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .core_release (core_release),
    .synth_en     (synth_en),
    .drp_en       (drp_en),
    .drp_rdy      (drp_rdy),
    .seq_busy     (seq_busy),
    .seq_rd_data  (seq_rd_data)
);

// File: tb/test_drp_bridge.sv
`timescale 1ns/1ps
module test_drp_bridge;

    localparam int CLKSEL_W = 8;
    localparam logic [8:0] A_RESET  = 9'h040;
    localparam logic [8:0] A_CLKSEL = 9'h044;
    localparam logic [8:0] A_CTRL   = 9'h070;
    localparam logic [8:0] A_STATUS = 9'h074;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                bus_wr = 1'b0;
    logic [8:0]          bus_addr = '0;
    logic [31:0]         bus_wdata = '0;
    logic [31:0]         bus_rdata;
    logic                core_release;
    logic                synth_en;
    logic [CLKSEL_W-1:0] clk_sel;
    logic                drp_en;
    logic                drp_we;
    logic [6:0]          drp_addr;
    logic [15:0]         drp_di;
    logic [15:0]         dut_do;
    logic                dut_rdy;

    // behavioural synthesizer responder
    logic [15:0] mem [128];
    logic [15:0] rsp_do;
    logic        rsp_rdy;
    logic        pend;
    logic        pend_we;
    logic [6:0]  pend_a;
    logic [15:0] pend_d;
    int          cnt;
    int          lat = 1;
    logic        stray = 1'b0;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    assign dut_do  = stray ? 16'hBEEF : rsp_do;
    assign dut_rdy = rsp_rdy | stray;

    drp_bridge #(.CLKSEL_W(CLKSEL_W)) i_drp_bridge (
        .clk          (clk),
        .rst          (rst),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .core_release (core_release),
        .synth_en     (synth_en),
        .clk_sel      (clk_sel),
        .drp_en       (drp_en),
        .drp_we       (drp_we),
        .drp_addr     (drp_addr),
        .drp_di       (drp_di),
        .drp_do       (dut_do),
        .drp_rdy      (dut_rdy)
    );

    always @(posedge clk) begin
        if (rst) begin
            rsp_rdy <= 1'b0;
            rsp_do  <= '0;
            pend    <= 1'b0;
            cnt     <= 0;
        end else begin
            rsp_rdy <= 1'b0;
            if (drp_en) begin
                pend    <= 1'b1;
                cnt     <= lat;
                pend_a  <= drp_addr;
                pend_we <= drp_we;
                pend_d  <= drp_di;
            end else if (pend) begin
                if (cnt == 0) begin
                    rsp_rdy <= 1'b1;
                    pend    <= 1'b0;
                    if (pend_we) mem[pend_a] <= pend_d;
                    else         rsp_do <= mem[pend_a];
                end else begin
                    cnt <= cnt - 1;
                end
            end
        end
    end

    function automatic logic [15:0] pat(input int a);
        logic [15:0] p;
        p = 16'(a * 16'h0397) ^ 16'hA5C3;
        return p;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // poll busy until the access finishes; checks the busy/ready timing (R6)
    task automatic wait_idle();
        logic [31:0] s;
        for (int g = 0; g < 200; g++) begin
            rd(A_STATUS, s);
            if (dut_rdy) begin
                chk("R6 busy held in ready cycle", {31'b0, s[16]}, 32'd1);
                @(negedge clk);
                rd(A_STATUS, s);
                chk("R6 busy cleared after ready", {31'b0, s[16]}, 32'd0);
                return;
            end
            @(negedge clk);
        end
        chk("R6 access never completed", 32'd0, 32'd1);
    endtask

    initial begin
        logic [31:0] v;
        logic [15:0] last_rd;
        for (int i = 0; i < 128; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(A_RESET, v);  chk("R1 reset reg", v, 32'd0);
        rd(A_CLKSEL, v); chk("R1 clksel reg", v, 32'd0);
        rd(A_STATUS, v); chk("R1 status reg", v, 32'd0);
        chk("R1 outputs", {28'b0, core_release, synth_en, drp_en, |clk_sel}, 32'd0);

        // R2 reset/enable register, all four values
        for (int k = 0; k < 4; k++) begin
            wr(A_RESET, 32'hFFFF_FFFC | 32'(k));
            chk("R2 core_release", {31'b0, core_release}, 32'(k & 1));
            chk("R2 synth_en", {31'b0, synth_en}, 32'((k >> 1) & 1));
            rd(A_RESET, v); chk("R2 readback", v, 32'(k));
        end

        // R3 clock select sweep
        for (int k = 0; k < 256; k++) begin
            wr(A_CLKSEL, 32'h5A00_0000 | 32'(k));
            chk("R3 clk_sel", {24'b0, clk_sel}, 32'(k));
            rd(A_CLKSEL, v); chk("R3 readback", v, 32'(k));
        end

        // R10 unmapped and write-only offsets read zero
        for (int a = 0; a < 512; a += 4) begin
            if (a != 9'h040 && a != 9'h044 && a != 9'h074) begin
                rd(9'(a), v);
                chk("R10 unmapped read", v, 32'd0);
            end
        end

        // R5 control write without the start bit
        wr(A_CTRL, 32'h1012_3456);
        chk("R5 no enable", {31'b0, drp_en}, 32'd0);
        rd(A_STATUS, v); chk("R5 not busy", v, 32'd0);

        // R4 R9 write sweep over every port address with varied latency
        last_rd = '0;
        for (int a = 0; a < 128; a++) begin
            lat = a % 6;
            wr(A_CTRL, (32'd1 << 29) | (32'(a & 31) << 23) | (32'(a) << 16) | 32'(pat(a)));
            chk("R4 enable pulse", {31'b0, drp_en}, 32'd1);
            chk("R4 write direction", {31'b0, drp_we}, 32'd1);
            chk("R9 address ignores upper bits", {25'b0, drp_addr}, 32'(a));
            chk("R4 write data", {16'b0, drp_di}, 32'(pat(a)));
            rd(A_STATUS, v); chk("R6 busy after accept", {31'b0, v[16]}, 32'd1);
            @(negedge clk);
            chk("R4 enable one cycle", {31'b0, drp_en}, 32'd0);
            wait_idle();
            rd(A_STATUS, v); chk("R8 write keeps read data", v, {16'b0, last_rd});
        end

        // R8 read sweep
        for (int a = 0; a < 128; a++) begin
            lat = (a * 7) % 5;
            wr(A_CTRL, (32'd3 << 28) | (32'((a * 3) & 31) << 23) | (32'(a) << 16) | 32'h0000_1234);
            chk("R4 read direction", {31'b0, drp_we}, 32'd0);
            chk("R9 read address", {25'b0, drp_addr}, 32'(a));
            wait_idle();
            rd(A_STATUS, v); chk("R8 read data latched", v, {16'b0, pat(a)});
            chk("R10 status upper bits", {15'b0, v[31:17]}, 32'd0);
        end

        // R7 control write while busy is ignored
        lat = 15;
        wr(A_CTRL, (32'd3 << 28) | (32'd5 << 16));
        @(negedge clk);
        wr(A_CTRL, (32'd1 << 29) | (32'd9 << 16) | 32'h0000_7777);
        chk("R7 no second enable", {31'b0, drp_en}, 32'd0);
        chk("R7 address kept", {25'b0, drp_addr}, 32'd5);
        chk("R7 direction kept", {31'b0, drp_we}, 32'd0);
        rd(A_STATUS, v); chk("R7 still busy", {31'b0, v[16]}, 32'd1);
        wait_idle();
        rd(A_STATUS, v); chk("R7 first access result", v, {16'b0, pat(5)});
        lat = 2;
        wr(A_CTRL, (32'd3 << 28) | (32'd9 << 16));
        wait_idle();
        rd(A_STATUS, v); chk("R7 ignored write left memory", v, {16'b0, pat(9)});

        // R8 hold across a later write
        wr(A_CTRL, (32'd1 << 29) | (32'd9 << 16) | 32'h0000_4242);
        wait_idle();
        rd(A_STATUS, v); chk("R8 hold after write", v, {16'b0, pat(9)});

        // R11 stray ready while idle
        @(negedge clk);
        stray = 1'b1;
        @(negedge clk);
        stray = 1'b0;
        rd(A_STATUS, v); chk("R11 stray ready ignored", v, {16'b0, pat(9)});
        @(negedge clk);
        rd(A_STATUS, v); chk("R11 still idle", v, {16'b0, pat(9)});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule